// File: doc/BRIEF.md
# Power Mode and Reset Sequencer

This block controls the low-power states and the reset qualification of a small 8-bit controller core. Software asks for a low-power state by writing a power-control word, either idle or power-down. The block then produces the clock enables for the CPU and the peripherals, an enable that keeps the oscillator running, a synchronous core reset and an inhibit on internal RAM writes. Everything runs on the oscillator clock. A machine cycle is twelve oscillator periods, and a phase counter broadcasts the position inside that cycle to the rest of the core.

Idle freezes only the CPU. The timers, the serial port and the interrupt logic keep their clock, and any enabled interrupt brings the CPU back. Power-down also stops the oscillator and ignores interrupts, so the only way out is the reset pin. After a power-down wake the core stays in reset until the oscillator reports ready for a programmed number of clocks. A pulse on the reset pin becomes a core reset only when it lasts two full machine cycles. When such a pulse arrives during idle, the CPU runs again before the reset is confirmed. For that window internal RAM writes are blocked and port writes are not.

Top module: `pwr_seq`

## Requirements
- R1: While `por_n` is low, `core_rst`, `cpu_ce`, `periph_ce` and `osc_run` are 1, `ram_wr_inhibit` is 0 and `phase` is 0. After `por_n` rises, `core_rst` clears on the first clock edge that samples `rst_pin` low.
- R2: `phase` counts 0 to 11 and wraps while the oscillator runs outside reset, in normal run, in idle and in the idle reset window. `cycle_end` is 1 exactly when `phase` is 11 in those states. `phase` is held at 0 during core reset and keeps its value in power-down.
- R3: In normal run, a write with the idle bit set (power-down bit clear) gives `cpu_ce`=0, `periph_ce`=1 and `osc_run`=1 from the next edge. A write with both bits clear changes nothing.
- R4: In idle, an `irq_req` sampled high with `rst_pin` low returns the block to normal run (`cpu_ce`=1) on that edge.
- R5: In normal run, a write with the power-down bit set gives `cpu_ce`, `periph_ce` and `osc_run` all 0 from the next edge.
- R6: In power-down, `irq_req` has no effect. The first edge that samples `rst_pin` high sets `osc_run`=1 and `core_rst`=1 with `cpu_ce`=0 and `periph_ce`=0.
- R7: In normal run, `core_rst` rises only on the 24th consecutive edge that samples `rst_pin` high. A high pulse of 23 edges has no effect.
- R8: In idle, an edge that samples `rst_pin` high sets `cpu_ce`=1 and `ram_wr_inhibit`=1 with `core_rst`=0. On the 24th consecutive high sample, `core_rst` becomes 1 and `ram_wr_inhibit` becomes 0. If the pin drops before that, the block returns to normal run with `ram_wr_inhibit`=0. A reset edge wins over an interrupt in the same cycle.
- R9: After a power-down wake, `core_rst` stays 1 and `cpu_ce` stays 0 until `osc_ready` has been sampled high on max(`osc_wait`,1) consecutive edges. A low sample restarts the count. After that, `core_rst` stays 1 with `cpu_ce`=1 until `rst_pin` is sampled low.
- R10: A write with both the idle and power-down bits set enters power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | Raw reset pin, sampled on `clk` |
| pcon_we | input | 1 | Power-control write strobe from the CPU |
| pcon_idle | input | 1 | Idle request bit of the write |
| pcon_pd | input | 1 | Power-down request bit of the write |
| irq_req | input | 1 | Any enabled interrupt pending |
| osc_ready | input | 1 | Oscillator stable indication |
| osc_wait | input | WAIT_W | Ready clocks required after a power-down wake |
| cpu_ce | output | 1 | CPU clock enable |
| periph_ce | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator run enable |
| core_rst | output | 1 | Synchronous core reset |
| ram_wr_inhibit | output | 1 | Blocks internal RAM writes |
| phase | output | PH_W | Oscillator period within the machine cycle |
| cycle_end | output | 1 | Last period of a machine cycle |

## Verification
The bench holds the reset pin high for 23 edges and then for 24. A filter that is one edge short resets the core on a glitch, and a filter that is one edge long leaves the CPU running beyond the intended window. The idle reset window is checked edge by edge for the RAM inhibit and for the later hand-over to core reset. A design that keeps the inhibit inside reset, or that leaves it set after an aborted glitch, fails these checks. The oscillator-ready count is broken by a low sample and restarted, which catches a counter that resumes instead of starting again. Interrupts sent during power-down, and a write with both request bits set, catch a design that wakes on an interrupt or that gives idle the priority.

// File: rtl/pwr_seq.sv
module pwr_seq #(
  parameter int MC_CLKS  = 12,
  parameter int RST_MCYC = 2,
  parameter int WAIT_W   = 8,
  localparam int PH_W     = $clog2(MC_CLKS),
  localparam int RST_CLKS = MC_CLKS * RST_MCYC,
  localparam int RC_W     = $clog2(RST_CLKS + 1)
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_pin,
  input  logic              pcon_we,
  input  logic              pcon_idle,
  input  logic              pcon_pd,
  input  logic              irq_req,
  input  logic              osc_ready,
  input  logic [WAIT_W-1:0] osc_wait,
  output logic              cpu_ce,
  output logic              periph_ce,
  output logic              osc_run,
  output logic              core_rst,
  output logic              ram_wr_inhibit,
  output logic [PH_W-1:0]   phase,
  output logic              cycle_end
);

  typedef enum logic [2:0] {S_RUN, S_IDLE, S_IRST, S_PD, S_WAKE, S_RST} st_t;

  st_t               st, st_n;
  logic [RC_W-1:0]   rcnt;
  logic [WAIT_W-1:0] wcnt;
  logic              counting, qual, ready_done;

  assign counting   = (st == S_RUN) || (st == S_IDLE) || (st == S_IRST);
  assign qual       = counting && rst_pin && (rcnt == RC_W'(RST_CLKS - 1));
  assign ready_done = osc_ready && (({1'b0, wcnt} + 1'b1) >= {1'b0, osc_wait});

  always_comb begin
    st_n = st;
    unique case (st)
      S_RUN:  if (qual) st_n = S_RST;
              else if (pcon_we && pcon_pd) st_n = S_PD;
              else if (pcon_we && pcon_idle) st_n = S_IDLE;
      S_IDLE: if (qual) st_n = S_RST;
              else if (rst_pin) st_n = S_IRST;
              else if (irq_req) st_n = S_RUN;
      S_IRST: if (qual) st_n = S_RST;
              else if (!rst_pin) st_n = S_RUN;
      S_PD:   if (rst_pin) st_n = S_WAKE;
      S_WAKE: if (ready_done) st_n = S_RST;
      S_RST:  if (!rst_pin) st_n = S_RUN;
      default: st_n = S_RST;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st    <= S_RST;
      rcnt  <= '0;
      wcnt  <= '0;
      phase <= '0;
    end else begin
      st    <= st_n;
      rcnt  <= (counting && rst_pin) ? rcnt + 1'b1 : '0;
      wcnt  <= (st == S_WAKE && osc_ready) ? wcnt + 1'b1 : '0;
      if (st == S_RST || st == S_WAKE)
        phase <= '0;
      else if (counting)
        phase <= (phase == PH_W'(MC_CLKS - 1)) ? '0 : phase + 1'b1;
    end
  end

  assign cpu_ce         = (st == S_RUN) || (st == S_IRST) || (st == S_RST);
  assign periph_ce      = cpu_ce || (st == S_IDLE);
  assign osc_run        = (st != S_PD);
  assign core_rst       = (st == S_RST) || (st == S_WAKE);
  assign ram_wr_inhibit = (st == S_IRST);
  assign cycle_end      = counting && (phase == PH_W'(MC_CLKS - 1));

  p_phase_range_r2: assert property (@(posedge clk) disable iff (!por_n)
    32'(phase) < MC_CLKS);
  p_pd_phase_frozen_r2: assert property (@(posedge clk) disable iff (!por_n)
    (!osc_run && !rst_pin) |=> $stable(phase));
  p_idle_exit_r4: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_IDLE && irq_req && !rst_pin) |=> (cpu_ce && !core_rst && !ram_wr_inhibit));
  p_pd_hold_r6: assert property (@(posedge clk) disable iff (!por_n)
    (!osc_run && !rst_pin) |=> !osc_run);
  p_filter_r7: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_pin && !core_rst) |=> !core_rst);
  p_window_r8: assert property (@(posedge clk) disable iff (!por_n)
    (ram_wr_inhibit && !rst_pin) |=> (!ram_wr_inhibit && !core_rst && cpu_ce));
  p_wake_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_WAKE && !osc_ready) |=> (core_rst && !cpu_ce));
  p_pd_prio_r10: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_RUN && pcon_we && pcon_pd && pcon_idle && !rst_pin) |=> (!osc_run && !periph_ce));

endmodule

// File: tb/pwr_seq_bench.sv
module pwr_seq_bench;
  logic       clk = 1'b0;
  logic       por_n, rst_pin, pcon_we, pcon_idle, pcon_pd, irq_req, osc_ready;
  logic [7:0] osc_wait;
  logic       cpu_ce, periph_ce, osc_run, core_rst, ram_wr_inhibit, cycle_end;
  logic [3:0] phase;
  int         n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  pwr_seq u_pwr_seq (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin), .pcon_we(pcon_we),
    .pcon_idle(pcon_idle), .pcon_pd(pcon_pd), .irq_req(irq_req),
    .osc_ready(osc_ready), .osc_wait(osc_wait), .cpu_ce(cpu_ce),
    .periph_ce(periph_ce), .osc_run(osc_run), .core_rst(core_rst),
    .ram_wr_inhibit(ram_wr_inhibit), .phase(phase), .cycle_end(cycle_end));

  typedef struct packed {
    logic       pd;
    logic       idle;
    logic [2:0] mode;
    logic [2:0] after;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b0, 1'b0, 3'b111, 3'b111},
    '{1'b0, 1'b1, 3'b011, 3'b111},
    '{1'b1, 1'b0, 3'b000, 3'b000},
    '{1'b1, 1'b1, 3'b000, 3'b000}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_pcon(input logic pd, input logic idle);
    pcon_we = 1'b1; pcon_pd = pd; pcon_idle = idle;
    tick(1);
    pcon_we = 1'b0; pcon_pd = 1'b0; pcon_idle = 1'b0;
  endtask

  task automatic full_reset();
    osc_ready = 1'b1;
    rst_pin = 1'b1;
    tick(30);
    rst_pin = 1'b0;
    tick(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] ph;
    por_n = 1'b0; rst_pin = 1'b0; pcon_we = 1'b0; pcon_idle = 1'b0; pcon_pd = 1'b0;
    irq_req = 1'b0; osc_ready = 1'b1; osc_wait = 8'd3;
    tick(2);
    chk("R1 reset outputs", {core_rst, cpu_ce, periph_ce, osc_run, ram_wr_inhibit}, 5'b11110);
    chk("R1 reset phase", phase, 0);
    por_n = 1'b1;
    tick(1);
    chk("R1 release", core_rst, 0);

    // R2 phase sequence in run
    ph = phase;
    for (int i = 0; i < 30; i++) begin
      tick(1);
      chk("R2 phase step", phase, (ph == 4'd11) ? 0 : ph + 1);
      chk("R2 cycle_end", cycle_end, phase == 4'd11);
      ph = phase;
    end

    // R3 R4 R5 R10 table walk
    foreach (VECS[k]) begin
      write_pcon(VECS[k].pd, VECS[k].idle);
      chk(VECS[k].pd ? (VECS[k].idle ? "R10 both bits" : "R5 pd entry") : "R3 idle entry",
          {cpu_ce, periph_ce, osc_run}, VECS[k].mode);
      irq_req = 1'b1;
      tick(1);
      irq_req = 1'b0;
      chk(VECS[k].pd ? "R6 irq ignored in pd" : "R4 irq exit",
          {cpu_ce, periph_ce, osc_run}, VECS[k].after);
      full_reset();
    end

    // R2 peripherals keep counting in idle
    write_pcon(1'b0, 1'b1);
    ph = phase;
    tick(1);
    chk("R2 idle phase runs", phase, (ph == 4'd11) ? 0 : ph + 1);
    irq_req = 1'b1; tick(1); irq_req = 1'b0;

    // R7 reset filter
    rst_pin = 1'b1;
    for (int i = 1; i <= 23; i++) begin
      tick(1);
      chk("R7 no reset before 24", core_rst, 0);
    end
    rst_pin = 1'b0;
    tick(1);
    chk("R7 23-edge pulse ignored", {core_rst, cpu_ce}, 2'b01);
    rst_pin = 1'b1;
    tick(23);
    chk("R7 still running at 23", core_rst, 0);
    tick(1);
    chk("R7 reset at 24", core_rst, 1);
    tick(1);
    chk("R2 phase held in reset", phase, 0);
    rst_pin = 1'b0;
    tick(1);
    chk("R1 reset released", core_rst, 0);

    // R8 idle reset window
    write_pcon(1'b0, 1'b1);
    rst_pin = 1'b1; irq_req = 1'b1;
    tick(1);
    irq_req = 1'b0;
    chk("R8 window opens", {cpu_ce, ram_wr_inhibit, core_rst}, 3'b110);
    tick(22);
    chk("R8 window at 23", {cpu_ce, ram_wr_inhibit, core_rst}, 3'b110);
    tick(1);
    chk("R8 handover at 24", {ram_wr_inhibit, core_rst}, 2'b01);
    rst_pin = 1'b0;
    tick(2);
    write_pcon(1'b0, 1'b1);
    rst_pin = 1'b1;
    tick(5);
    rst_pin = 1'b0;
    tick(1);
    chk("R8 glitch returns to run", {cpu_ce, ram_wr_inhibit, core_rst}, 3'b100);

    // R6 R9 power-down wake
    write_pcon(1'b1, 1'b0);
    ph = phase;
    irq_req = 1'b1;
    tick(10);
    irq_req = 1'b0;
    chk("R6 pd holds", {osc_run, periph_ce}, 2'b00);
    chk("R2 phase frozen in pd", phase, ph);
    osc_ready = 1'b0; rst_pin = 1'b1;
    tick(1);
    chk("R6 wake", {osc_run, core_rst, cpu_ce, periph_ce}, 4'b1100);
    tick(10);
    chk("R9 wait for ready", {core_rst, cpu_ce}, 2'b10);
    osc_ready = 1'b1;
    tick(2);
    chk("R9 two ready samples", {core_rst, cpu_ce}, 2'b10);
    osc_ready = 1'b0;
    tick(1);
    osc_ready = 1'b1;
    tick(2);
    chk("R9 count restarted", {core_rst, cpu_ce}, 2'b10);
    tick(1);
    chk("R9 third ready sample", {core_rst, cpu_ce}, 2'b11);
    rst_pin = 1'b0;
    tick(1);
    chk("R9 release", {core_rst, cpu_ce, osc_run}, 3'b011);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule